// File: doc/BRIEF.md
# EDH Field CRC Checker

This block checks standard-definition serial digital video for transmission errors. For every video field it builds two CRC words over the incoming 10-bit word stream: one over the active picture and one over the full field. When the error-detection packet for a field arrives, already parsed, the received check words are compared with the values built locally. Any mismatch raises one of two sticky error flags. Both fields share the same pair of flags.

The window that feeds each CRC is chosen from three sources:

- **Fixed tables.** Used for the 525-line and 625-line component formats.
- **Host line ranges.** Used for any other format, when the host has programmed them sensibly.
- **Timing-derived window.** Used otherwise. It covers every line of the field.

Within a line, only the words between the start-of-active-video and end-of-active-video sequences are counted. The flywheel's horizontal blanking signal marks those words.

The flywheel supplies the line number, the field bit and the blanking signal. A packet parser supplies the received CRC words together with a strobe and a packet-good bit.

Top module: `edh_crc_check`

## Requirements
- R1: Each CRC uses the polynomial x^16+x^12+x^5+1, starts from zero at the first word of each field, and takes in every window word most significant bit first. A window word is one with `hblank` low whose line lies inside the selected line range.
- R2: With `fmt` = 0 (525-line), the line ranges are fixed:
  - field 1 (`field`=0): active picture 21..262, full field 12..262;
  - field 2 (`field`=1): active picture 284..525, full field 275..525.
- R3: With `fmt` = 1 (625-line), the line ranges are fixed:
  - field 1: active picture 24..310, full field 6..310;
  - field 2: active picture 336..623, full field 319..623.
- R4: With `fmt` = 2 or 3, the host start/end lines for the current field and window kind set the inclusive line range. This applies only when all eight host registers are non-zero and correctly ordered.
- R5: When any host range register is zero, a non-standard format uses the timing-derived window. That window includes every line of the field, so the active-picture and full-field CRCs are equal.
- R6: When any host end line is below its start line, a non-standard format also falls back to the timing-derived window.
- R7: On `rx_valid`, the CRCs latched for field `rx_field` are compared with `rx_ap_crc` and `rx_ff_crc`. An active-picture mismatch sets `ap_crc_err` and a full-field mismatch sets `ff_crc_err`, for either field, one cycle after the strobe.
- R8: A comparison takes place only when `sd_mode` and `rx_ok` are both high during the strobe; otherwise the flags are left unchanged.
- R9: The flags are sticky until `err_clr`, which clears both one cycle later and wins over a setting event in the same cycle.
- R10: After reset both flags are low.
- R11: Each latched field result is compared at most once. A strobe for a field with no fresh latched result (already consumed, or not yet closed since reset) leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_word | input | WORD_W | Video word stream |
| hblank | input | 1 | High from EAV through SAV; low on picture words |
| field | input | 1 | Flywheel field bit, 0 = field 1 |
| line_num | input | LINE_W | Flywheel line number |
| fmt | input | 2 | Format: 0 = 525, 1 = 625, 2/3 = other |
| sd_mode | input | 1 | High while in standard-definition mode |
| hst_ap_lo_f1 | input | LINE_W | Field 1 active-picture first line |
| hst_ap_hi_f1 | input | LINE_W | Field 1 active-picture last line |
| hst_ff_lo_f1 | input | LINE_W | Field 1 full-field first line |
| hst_ff_hi_f1 | input | LINE_W | Field 1 full-field last line |
| hst_ap_lo_f2 | input | LINE_W | Field 2 active-picture first line |
| hst_ap_hi_f2 | input | LINE_W | Field 2 active-picture last line |
| hst_ff_lo_f2 | input | LINE_W | Field 2 full-field first line |
| hst_ff_hi_f2 | input | LINE_W | Field 2 full-field last line |
| rx_valid | input | 1 | Received CRC strobe |
| rx_ok | input | 1 | Packet for this strobe was received correctly |
| rx_field | input | 1 | Field the received CRCs belong to |
| rx_ap_crc | input | 16 | Received active-picture CRC |
| rx_ff_crc | input | 16 | Received full-field CRC |
| err_clr | input | 1 | Clears both error flags |
| ap_crc_err | output | 1 | Sticky active-picture CRC error |
| ff_crc_err | output | 1 | Sticky full-field CRC error |

## Verification
The bench keeps the defaults `WORD_W`=10 and `LINE_W`=11, but drives lines only five words long: two blanking words and three picture words. With such short lines, complete 525-line and 625-line frames take only a few thousand cycles each. Every boundary line of the fixed tables is therefore exercised against a CRC the bench computes arithmetically. Short 40-line frames cover the host and timing-derived ranges. On those frames, a one-line slip of any window edge changes the CRC and shows up as a raised flag.

// File: rtl/edh_pkg.sv
package edh_pkg;

  localparam int CRC_W    = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam int TBL_W    = 10;
  localparam int NFLD     = 2;
  localparam int NKIND    = 2;   // kind 0: active picture, kind 1: full field

  typedef enum logic [1:0] {
    SRC_TABLE  = 2'd0,
    SRC_HOST   = 2'd1,
    SRC_TIMING = 2'd2
  } win_src_e;

  // Advance a CRC by one word of nbits bits, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [15:0]      d,
                                                input int               nbits);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      if (i < nbits) begin
        fb = r[CRC_W-1] ^ d[i];
        r  = {r[CRC_W-2:0], 1'b0};
        if (fb) r = r ^ CRC_POLY;
      end
    end
    return r;
  endfunction

  // First line of a standard window; is_ff selects full field over active picture.
  function automatic logic [TBL_W-1:0] tbl_first(input logic is625,
                                                 input logic fld,
                                                 input logic is_ff);
    logic [TBL_W-1:0] v;
    case ({is625, fld, is_ff})
      3'b000:  v = 10'd21;
      3'b001:  v = 10'd12;
      3'b010:  v = 10'd284;
      3'b011:  v = 10'd275;
      3'b100:  v = 10'd24;
      3'b101:  v = 10'd6;
      3'b110:  v = 10'd336;
      default: v = 10'd319;
    endcase
    return v;
  endfunction

  // Last line of a standard window (same for both kinds).
  function automatic logic [TBL_W-1:0] tbl_last(input logic is625,
                                                input logic fld);
    logic [TBL_W-1:0] v;
    case ({is625, fld})
      2'b00:   v = 10'd262;
      2'b01:   v = 10'd525;
      2'b10:   v = 10'd310;
      default: v = 10'd623;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/edh_window.sv
module edh_window
  import edh_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic [1:0]        fmt,
  input  logic              field,
  input  logic              hblank,
  input  logic [LINE_W-1:0] line_num,
  input  logic [LINE_W-1:0] hst_ap_lo_f1,
  input  logic [LINE_W-1:0] hst_ap_hi_f1,
  input  logic [LINE_W-1:0] hst_ff_lo_f1,
  input  logic [LINE_W-1:0] hst_ff_hi_f1,
  input  logic [LINE_W-1:0] hst_ap_lo_f2,
  input  logic [LINE_W-1:0] hst_ap_hi_f2,
  input  logic [LINE_W-1:0] hst_ff_lo_f2,
  input  logic [LINE_W-1:0] hst_ff_hi_f2,
  output logic [NKIND-1:0]  kind_win,
  output win_src_e          win_src
);

  // Host ranges indexed [kind][field].
  logic [NKIND-1:0][NFLD-1:0][LINE_W-1:0] h_lo;
  logic [NKIND-1:0][NFLD-1:0][LINE_W-1:0] h_hi;
  logic host_has_zero;
  logic host_misorder;
  logic is_std;

  assign h_lo[0][0] = hst_ap_lo_f1;
  assign h_hi[0][0] = hst_ap_hi_f1;
  assign h_lo[1][0] = hst_ff_lo_f1;
  assign h_hi[1][0] = hst_ff_hi_f1;
  assign h_lo[0][1] = hst_ap_lo_f2;
  assign h_hi[0][1] = hst_ap_hi_f2;
  assign h_lo[1][1] = hst_ff_lo_f2;
  assign h_hi[1][1] = hst_ff_hi_f2;

  assign is_std = ~fmt[1];

  always_comb begin
    host_has_zero = 1'b0;
    host_misorder = 1'b0;
    for (int k = 0; k < NKIND; k++) begin
      for (int f = 0; f < NFLD; f++) begin
        if (h_lo[k][f] == '0 || h_hi[k][f] == '0) host_has_zero = 1'b1;
        if (h_hi[k][f] < h_lo[k][f])              host_misorder = 1'b1;
      end
    end
  end

  always_comb begin
    if (is_std)                              win_src = SRC_TABLE;
    else if (host_has_zero || host_misorder) win_src = SRC_TIMING;
    else                                     win_src = SRC_HOST;
  end

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    logic [LINE_W-1:0] t_lo;
    logic [LINE_W-1:0] t_hi;
    logic              line_ok;

    assign t_lo = LINE_W'(tbl_first(fmt[0], field, k[0]));
    assign t_hi = LINE_W'(tbl_last(fmt[0], field));

    always_comb begin
      case (win_src)
        SRC_TABLE: line_ok = (line_num >= t_lo) && (line_num <= t_hi);
        SRC_HOST:  line_ok = (line_num >= h_lo[k][field]) &&
                             (line_num <= h_hi[k][field]);
        default:   line_ok = 1'b1;
      endcase
    end

    assign kind_win[k] = ~hblank & line_ok;
  end

endmodule

// File: rtl/edh_crc_acc.sv
module edh_crc_acc
  import edh_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WORD_W-1:0]          word,
  input  logic                       win,
  input  logic                       restart,
  input  logic                       latch,
  input  logic                       latch_fld,
  output logic [NFLD-1:0][CRC_W-1:0] held
);

  logic [CRC_W-1:0] acc;
  logic [CRC_W-1:0] acc_from_zero;
  logic [CRC_W-1:0] acc_next;

  assign acc_from_zero = crc_step('0,  16'(word), WORD_W);
  assign acc_next      = crc_step(acc, 16'(word), WORD_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (restart) begin
      acc <= win ? acc_from_zero : '0;
    end else if (win) begin
      acc <= acc_next;
    end
  end

  for (genvar f = 0; f < NFLD; f++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held[f] <= '0;
      end else if (latch && (latch_fld == f[0])) begin
        held[f] <= acc;
      end
    end
  end

endmodule

// File: rtl/edh_flag_unit.sv
module edh_flag_unit
  import edh_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NFLD-1:0][CRC_W-1:0] held_ap,
  input  logic [NFLD-1:0][CRC_W-1:0] held_ff,
  input  logic                       latch_en,
  input  logic                       latch_fld,
  input  logic                       rx_valid,
  input  logic                       rx_ok,
  input  logic                       rx_field,
  input  logic [CRC_W-1:0]           rx_ap_crc,
  input  logic [CRC_W-1:0]           rx_ff_crc,
  input  logic                       sd_mode,
  input  logic                       err_clr,
  output logic                       ap_err,
  output logic                       ff_err,
  output logic                       cmp_go,
  output logic                       ap_miss,
  output logic                       ff_miss
);

  logic [NFLD-1:0] fresh;

  assign cmp_go  = rx_valid & rx_ok & sd_mode & fresh[rx_field];
  assign ap_miss = held_ap[rx_field] != rx_ap_crc;
  assign ff_miss = held_ff[rx_field] != rx_ff_crc;

  for (genvar f = 0; f < NFLD; f++) begin : g_fresh
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fresh[f] <= 1'b0;
      end else if (latch_en && (latch_fld == f[0])) begin
        fresh[f] <= 1'b1;
      end else if (rx_valid && (rx_field == f[0])) begin
        fresh[f] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_err <= 1'b0;
      ff_err <= 1'b0;
    end else if (err_clr) begin
      ap_err <= 1'b0;
      ff_err <= 1'b0;
    end else begin
      if (cmp_go && ap_miss) ap_err <= 1'b1;
      if (cmp_go && ff_miss) ff_err <= 1'b1;
    end
  end

endmodule

// File: rtl/edh_crc_check.sv
module edh_crc_check
  import edh_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] vid_word,
  input  logic              hblank,
  input  logic              field,
  input  logic [LINE_W-1:0] line_num,
  input  logic [1:0]        fmt,
  input  logic              sd_mode,
  input  logic [LINE_W-1:0] hst_ap_lo_f1,
  input  logic [LINE_W-1:0] hst_ap_hi_f1,
  input  logic [LINE_W-1:0] hst_ff_lo_f1,
  input  logic [LINE_W-1:0] hst_ff_hi_f1,
  input  logic [LINE_W-1:0] hst_ap_lo_f2,
  input  logic [LINE_W-1:0] hst_ap_hi_f2,
  input  logic [LINE_W-1:0] hst_ff_lo_f2,
  input  logic [LINE_W-1:0] hst_ff_hi_f2,
  input  logic              rx_valid,
  input  logic              rx_ok,
  input  logic              rx_field,
  input  logic [15:0]       rx_ap_crc,
  input  logic [15:0]       rx_ff_crc,
  input  logic              err_clr,
  output logic              ap_crc_err,
  output logic              ff_crc_err
);

  // Field boundary tracking
  logic field_q;
  logic armed;
  logic fld_edge;
  logic latch_en;

  assign fld_edge = field ^ field_q;
  assign latch_en = fld_edge & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= 1'b0;
      armed   <= 1'b0;
    end else begin
      field_q <= field;
      if (fld_edge) armed <= 1'b1;
    end
  end

  // Window selection
  logic [NKIND-1:0] kind_win;
  win_src_e         win_src;
  logic             ap_win;
  logic             ff_win;

  edh_window #(.LINE_W(LINE_W)) u_window (
    .fmt          (fmt),
    .field        (field),
    .hblank       (hblank),
    .line_num     (line_num),
    .hst_ap_lo_f1 (hst_ap_lo_f1),
    .hst_ap_hi_f1 (hst_ap_hi_f1),
    .hst_ff_lo_f1 (hst_ff_lo_f1),
    .hst_ff_hi_f1 (hst_ff_hi_f1),
    .hst_ap_lo_f2 (hst_ap_lo_f2),
    .hst_ap_hi_f2 (hst_ap_hi_f2),
    .hst_ff_lo_f2 (hst_ff_lo_f2),
    .hst_ff_hi_f2 (hst_ff_hi_f2),
    .kind_win     (kind_win),
    .win_src      (win_src)
  );

  assign ap_win = kind_win[0];
  assign ff_win = kind_win[1];

  // One accumulator per window kind
  logic [NKIND-1:0][NFLD-1:0][CRC_W-1:0] held;

  for (genvar k = 0; k < NKIND; k++) begin : g_acc
    edh_crc_acc #(.WORD_W(WORD_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .word      (vid_word),
      .win       (kind_win[k]),
      .restart   (fld_edge),
      .latch     (latch_en),
      .latch_fld (field_q),
      .held      (held[k])
    );
  end

  // Comparison and flags
  logic cmp_go;
  logic ap_miss;
  logic ff_miss;

  edh_flag_unit u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .held_ap   (held[0]),
    .held_ff   (held[1]),
    .latch_en  (latch_en),
    .latch_fld (field_q),
    .rx_valid  (rx_valid),
    .rx_ok     (rx_ok),
    .rx_field  (rx_field),
    .rx_ap_crc (rx_ap_crc),
    .rx_ff_crc (rx_ff_crc),
    .sd_mode   (sd_mode),
    .err_clr   (err_clr),
    .ap_err    (ap_crc_err),
    .ff_err    (ff_crc_err),
    .cmp_go    (cmp_go),
    .ap_miss   (ap_miss),
    .ff_miss   (ff_miss)
  );

endmodule

// File: rtl/edh_crc_check_sva.sv
module edh_crc_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       sd_mode,
  input logic       rx_valid,
  input logic       rx_ok,
  input logic       err_clr,
  input logic       ap_crc_err,
  input logic       ff_crc_err,
  input logic       ap_win,
  input logic       ff_win,
  input logic [1:0] win_src,
  input logic       cmp_go,
  input logic       ap_miss,
  input logic       ff_miss
);

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (!ap_crc_err && !ff_crc_err));

  p_ap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_crc_err && !err_clr) |=> ap_crc_err);

  p_ff_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_crc_err && !err_clr) |=> ff_crc_err);

  p_ap_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ap_crc_err) |-> $past(cmp_go && ap_miss));

  p_ff_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ff_crc_err) |-> $past(cmp_go && ff_miss));

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ap_crc_err) || $rose(ff_crc_err)) |-> $past(sd_mode && rx_ok && rx_valid));

  p_timing_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_src == 2'd2) |-> (ap_win == ff_win));

  p_table_nest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_src == 2'd0) && ap_win) |-> ff_win);

endmodule

bind edh_crc_check edh_crc_check_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .sd_mode    (sd_mode),
  .rx_valid   (rx_valid),
  .rx_ok      (rx_ok),
  .err_clr    (err_clr),
  .ap_crc_err (ap_crc_err),
  .ff_crc_err (ff_crc_err),
  .ap_win     (ap_win),
  .ff_win     (ff_win),
  .win_src    (win_src),
  .cmp_go     (cmp_go),
  .ap_miss    (ap_miss),
  .ff_miss    (ff_miss)
);

// File: tb/test_edh_crc_check.sv
`timescale 1ns/1ps
module test_edh_crc_check;

  localparam int WORD_W = 10;
  localparam int LINE_W = 11;
  localparam int BLANK  = 2;
  localparam int ACT    = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [WORD_W-1:0] vid_word;
  logic              hblank;
  logic              field;
  logic [LINE_W-1:0] line_num;
  logic [1:0]        fmt;
  logic              sd_mode;
  logic [LINE_W-1:0] hst_ap_lo_f1, hst_ap_hi_f1, hst_ff_lo_f1, hst_ff_hi_f1;
  logic [LINE_W-1:0] hst_ap_lo_f2, hst_ap_hi_f2, hst_ff_lo_f2, hst_ff_hi_f2;
  logic              rx_valid, rx_ok, rx_field, err_clr;
  logic [15:0]       rx_ap_crc, rx_ff_crc;
  logic              ap_crc_err, ff_crc_err;

  always #2.5 clk = ~clk;

  edh_crc_check #(.WORD_W(WORD_W), .LINE_W(LINE_W)) i_edh_crc_check (
    .clk(clk), .rst_n(rst_n), .vid_word(vid_word), .hblank(hblank),
    .field(field), .line_num(line_num), .fmt(fmt), .sd_mode(sd_mode),
    .hst_ap_lo_f1(hst_ap_lo_f1), .hst_ap_hi_f1(hst_ap_hi_f1),
    .hst_ff_lo_f1(hst_ff_lo_f1), .hst_ff_hi_f1(hst_ff_hi_f1),
    .hst_ap_lo_f2(hst_ap_lo_f2), .hst_ap_hi_f2(hst_ap_hi_f2),
    .hst_ff_lo_f2(hst_ff_lo_f2), .hst_ff_hi_f2(hst_ff_hi_f2),
    .rx_valid(rx_valid), .rx_ok(rx_ok), .rx_field(rx_field),
    .rx_ap_crc(rx_ap_crc), .rx_ff_crc(rx_ff_crc), .err_clr(err_clr),
    .ap_crc_err(ap_crc_err), .ff_crc_err(ff_crc_err)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // Expected CRCs per field: index 0 = field 1, 1 = field 2
  logic [15:0] e_ap [2];
  logic [15:0] e_ff [2];

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // CRC restated as division by 0x11021, one bit at a time on an integer
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [9:0] w);
    int r;
    r = c;
    for (int b = 9; b >= 0; b--) begin
      r = r ^ (int'(w[b]) << 15);
      r = r << 1;
      if (r & 32'h10000) r = r ^ 32'h11021;
      r = r & 32'hFFFF;
    end
    return r[15:0];
  endfunction

  function automatic int host_val(input bit ap, input bit fld, input bit hi);
    case ({ap, fld, hi})
      3'b100: return int'(hst_ap_lo_f1);
      3'b101: return int'(hst_ap_hi_f1);
      3'b110: return int'(hst_ap_lo_f2);
      3'b111: return int'(hst_ap_hi_f2);
      3'b000: return int'(hst_ff_lo_f1);
      3'b001: return int'(hst_ff_hi_f1);
      3'b010: return int'(hst_ff_lo_f2);
      default: return int'(hst_ff_hi_f2);
    endcase
  endfunction

  function automatic bit host_usable();
    for (int c = 0; c < 8; c++) begin
      int lo, hi;
      lo = host_val(c[2], c[1], 1'b0);
      hi = host_val(c[2], c[1], 1'b1);
      if (lo == 0 || hi == 0 || hi < lo) return 0;
    end
    return 1;
  endfunction

  function automatic bit line_in(input int ln, input bit fld, input bit ap);
    int lo, hi;
    if (fmt == 2'd0) begin
      lo = fld ? (ap ? 284 : 275) : (ap ? 21 : 12);
      hi = fld ? 525 : 262;
    end else if (fmt == 2'd1) begin
      lo = fld ? (ap ? 336 : 319) : (ap ? 24 : 6);
      hi = fld ? 623 : 310;
    end else if (host_usable()) begin
      lo = host_val(ap, fld, 1'b0);
      hi = host_val(ap, fld, 1'b1);
    end else begin
      return 1;
    end
    return (ln >= lo) && (ln <= hi);
  endfunction

  task automatic drive_line(input int ln, input bit fld, input bit model);
    for (int p = 0; p < BLANK + ACT; p++) begin
      logic [9:0] w;
      w = 10'(((ln * 53 + p * 29 + 7) ^ (ln << 3)) & 32'h3FF);
      @(negedge clk);
      vid_word = w;
      hblank   = (p < BLANK);
      field    = fld;
      line_num = LINE_W'(ln);
      if (model && p >= BLANK) begin
        if (line_in(ln, fld, 1'b1)) e_ap[fld] = ref_crc(e_ap[fld], w);
        if (line_in(ln, fld, 1'b0)) e_ff[fld] = ref_crc(e_ff[fld], w);
      end
    end
  endtask

  task automatic run_frame(input int nl, input int f2s);
    e_ap[0] = '0; e_ap[1] = '0; e_ff[0] = '0; e_ff[1] = '0;
    drive_line(nl, 1'b1, 1'b0);
    for (int ln = 1; ln <= nl; ln++) drive_line(ln, ln >= f2s, 1'b1);
    drive_line(1, 1'b0, 1'b0);
    @(negedge clk);
    hblank = 1'b1;
  endtask

  task automatic strobe(input bit fld, input logic [15:0] ap, input logic [15:0] ff,
                        input bit ok, input bit sd, input bit clr);
    @(negedge clk);
    rx_valid = 1'b1; rx_field = fld; rx_ap_crc = ap; rx_ff_crc = ff;
    rx_ok = ok; sd_mode = sd; err_clr = clr;
    @(negedge clk);
    rx_valid = 1'b0; rx_ok = 1'b1; sd_mode = 1'b1; err_clr = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic set_host(input int a1l, a1h, f1l, f1h, a2l, a2h, f2l, f2h);
    hst_ap_lo_f1 = LINE_W'(a1l); hst_ap_hi_f1 = LINE_W'(a1h);
    hst_ff_lo_f1 = LINE_W'(f1l); hst_ff_hi_f1 = LINE_W'(f1h);
    hst_ap_lo_f2 = LINE_W'(a2l); hst_ap_hi_f2 = LINE_W'(a2h);
    hst_ff_lo_f2 = LINE_W'(f2l); hst_ff_hi_f2 = LINE_W'(f2h);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; vid_word = '0; hblank = 1'b1; field = 1'b0; line_num = '0;
    fmt = 2'd0; sd_mode = 1'b1; rx_valid = 1'b0; rx_ok = 1'b1; rx_field = 1'b0;
    rx_ap_crc = '0; rx_ff_crc = '0; err_clr = 1'b0;
    set_host(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset ap", ap_crc_err, 1'b0);
    check("R10 reset ff", ff_crc_err, 1'b0);

    // R11: strobe before any field closed
    strobe(1'b0, 16'hDEAD, 16'hBEEF, 1'b1, 1'b1, 1'b0);
    check("R11 no latched field ap", ap_crc_err, 1'b0);
    check("R11 no latched field ff", ff_crc_err, 1'b0);

    // R2 / R1: 525-line table, matching values
    fmt = 2'd0;
    run_frame(525, 263);
    strobe(1'b0, e_ap[0], e_ff[0], 1'b1, 1'b1, 1'b0);
    check("R2 525 f1 ap match", ap_crc_err, 1'b0);
    check("R1 525 f1 ff match", ff_crc_err, 1'b0);
    strobe(1'b1, e_ap[1], e_ff[1], 1'b1, 1'b1, 1'b0);
    check("R2 525 f2 ap match", ap_crc_err, 1'b0);
    check("R2 525 f2 ff match", ff_crc_err, 1'b0);
    strobe(1'b0, ~e_ap[0], ~e_ff[0], 1'b1, 1'b1, 1'b0);
    check("R11 consumed field ap", ap_crc_err, 1'b0);
    check("R11 consumed field ff", ff_crc_err, 1'b0);

    // R7 / R9: mismatches on separate fields share the flags
    run_frame(525, 263);
    strobe(1'b0, e_ap[0] ^ 16'h0001, e_ff[0], 1'b1, 1'b1, 1'b0);
    check("R7 f1 ap mismatch sets", ap_crc_err, 1'b1);
    check("R7 f1 ff match stays", ff_crc_err, 1'b0);
    strobe(1'b1, e_ap[1], e_ff[1] ^ 16'h8000, 1'b1, 1'b1, 1'b0);
    check("R9 ap sticky", ap_crc_err, 1'b1);
    check("R7 f2 ff mismatch sets", ff_crc_err, 1'b1);
    clear_flags();
    check("R9 clear ap", ap_crc_err, 1'b0);
    check("R9 clear ff", ff_crc_err, 1'b0);

    // R3: 625-line table
    fmt = 2'd1;
    run_frame(625, 313);
    strobe(1'b0, e_ap[0], e_ff[0], 1'b1, 1'b1, 1'b0);
    check("R3 625 f1 ap", ap_crc_err, 1'b0);
    check("R3 625 f1 ff", ff_crc_err, 1'b0);
    strobe(1'b1, e_ap[1], e_ff[1], 1'b1, 1'b1, 1'b0);
    check("R3 625 f2 ap", ap_crc_err, 1'b0);
    check("R3 625 f2 ff", ff_crc_err, 1'b0);

    // R4: host ranges, format code 2
    fmt = 2'd2;
    set_host(5, 15, 2, 18, 25, 35, 22, 38);
    run_frame(40, 21);
    strobe(1'b0, e_ap[0], e_ff[0], 1'b1, 1'b1, 1'b0);
    check("R4 host f1 ap", ap_crc_err, 1'b0);
    check("R4 host f1 ff", ff_crc_err, 1'b0);
    strobe(1'b1, e_ap[1], e_ff[1], 1'b1, 1'b1, 1'b0);
    check("R4 host f2 ap", ap_crc_err, 1'b0);
    check("R4 host f2 ff", ff_crc_err, 1'b0);

    // R4: host ranges, format code 3, edge-of-field ranges, with one mismatch
    fmt = 2'd3;
    set_host(1, 20, 1, 20, 21, 40, 21, 39);
    run_frame(40, 21);
    strobe(1'b0, e_ap[0], e_ff[0], 1'b1, 1'b1, 1'b0);
    check("R4 fmt3 f1 ap", ap_crc_err, 1'b0);
    check("R4 fmt3 f1 ff", ff_crc_err, 1'b0);
    strobe(1'b1, e_ap[1], e_ff[1] ^ 16'h0100, 1'b1, 1'b1, 1'b0);
    check("R4 fmt3 f2 ap", ap_crc_err, 1'b0);
    check("R7 fmt3 f2 ff mismatch", ff_crc_err, 1'b1);
    clear_flags();

    // R5: a zero register selects the timing window
    fmt = 2'd2;
    set_host(5, 15, 2, 18, 25, 35, 22, 0);
    run_frame(40, 21);
    check("R5 timing windows equal f1", e_ap[0] == e_ff[0], 1'b1);
    strobe(1'b0, e_ap[0], e_ff[0], 1'b1, 1'b1, 1'b0);
    check("R5 timing f1 ap", ap_crc_err, 1'b0);
    check("R5 timing f1 ff", ff_crc_err, 1'b0);
    strobe(1'b1, e_ap[1], e_ff[1], 1'b1, 1'b1, 1'b0);
    check("R5 timing f2 ap", ap_crc_err, 1'b0);
    check("R5 timing f2 ff", ff_crc_err, 1'b0);

    // R6: misordered range selects the timing window
    set_host(15, 5, 2, 18, 25, 35, 22, 38);
    run_frame(40, 21);
    strobe(1'b0, e_ap[0], e_ff[0], 1'b1, 1'b1, 1'b0);
    check("R6 misorder f1 ap", ap_crc_err, 1'b0);
    check("R6 misorder f1 ff", ff_crc_err, 1'b0);
    strobe(1'b1, e_ap[1], e_ff[1], 1'b1, 1'b1, 1'b0);
    check("R6 misorder f2 ap", ap_crc_err, 1'b0);
    check("R6 misorder f2 ff", ff_crc_err, 1'b0);

    // R8: gating by SD mode and packet-good
    set_host(5, 15, 2, 18, 25, 35, 22, 38);
    run_frame(40, 21);
    strobe(1'b0, ~e_ap[0], ~e_ff[0], 1'b1, 1'b0, 1'b0);
    check("R8 sd low ap", ap_crc_err, 1'b0);
    check("R8 sd low ff", ff_crc_err, 1'b0);
    strobe(1'b1, ~e_ap[1], ~e_ff[1], 1'b0, 1'b1, 1'b0);
    check("R8 bad packet ap", ap_crc_err, 1'b0);
    check("R8 bad packet ff", ff_crc_err, 1'b0);

    // R9 clear priority, then R8 positive case
    run_frame(40, 21);
    strobe(1'b0, ~e_ap[0], ~e_ff[0], 1'b1, 1'b1, 1'b1);
    check("R9 clear wins ap", ap_crc_err, 1'b0);
    check("R9 clear wins ff", ff_crc_err, 1'b0);
    strobe(1'b1, ~e_ap[1], ~e_ff[1], 1'b1, 1'b1, 1'b0);
    check("R8 gated compare ap", ap_crc_err, 1'b1);
    check("R8 gated compare ff", ff_crc_err, 1'b1);
    clear_flags();

    finish_run();
  end

endmodule